// File: doc/BRIEF.md
# Drifting-Clock Audio Sample FIFO with Flush on Overflow

This block carries audio samples from a signal-processing chain to an audio converter when the two sides run from separate oscillators. The producer side runs a little faster than the consumer. With the intended rates, about 48.076 kHz in and 48 kHz out, roughly 76 extra samples arrive each second. The block does not push back on the producer and does not resample. It lets the buffer fill. When a sample arrives and the buffer is already full, that sample is dropped and the whole buffer is emptied in one step. The listener hears a short click, and the queue starts again from empty. With the default 1024-entry store this happens about every 13 seconds.

The write side takes a valid strobe and a data word on its own clock. The read side takes a request on the audio clock and returns a registered word one cycle later. The read and write positions cross between the clock domains as Gray codes through two-flop synchronizers.

A flush is started on the write side. It signals the read side with a toggle, and the write side does not resume until the read side has reset its position and confirmed it. Writes that arrive during this recovery are dropped. On an empty buffer, a request repeats the last word delivered and raises an underflow flag. A saturating counter of flush events is available for debug.

Top module: `afq_top`

## Requirements
- R1: After reset, rd_data is 0, rd_underflow is 0 and flush_count is 0.
- R2: Words that were written and not flushed are returned by successive read requests in the order they were written, one word per request, on the rd_data register one read-clock cycle after the request.
- R3: A request while the buffer holds nothing leaves rd_data unchanged, so the last delivered word repeats, and sets rd_underflow high in the following read-clock cycle.
- R4: The buffer holds exactly 2^AW words (1024 by default) without a flush, and each of them reads back correctly. A valid write that finds the buffer full is dropped, empties the buffer, and raises flush_count by one in the next write-clock cycle.
- R5: After a flush, no word written before it can be read. Requests underflow until new words arrive, and the first word returned is the first word written after recovery.
- R6: flush_count saturates at 2^CW-1 and never wraps.
- R7: rd_data changes only in the cycle after a request that returns a word. rd_underflow is 0 for such requests and for cycles without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Producer clock |
| wrst_n | input | 1 | Producer-side asynchronous active-low reset |
| wr_valid | input | 1 | Sample present on wr_data this cycle |
| wr_data | input | DW | Sample from the producer |
| flush_count | output | CW | Saturating count of flush events (write domain) |
| rclk | input | 1 | Audio consumer clock |
| rrst_n | input | 1 | Consumer-side asynchronous active-low reset |
| rd_req | input | 1 | Consumer asks for the next sample |
| rd_data | output | DW | Registered sample, updated after a served request |
| rd_underflow | output | 1 | High the cycle after a request that found the buffer empty |

## Verification
Several patterns are used, and each separates a different kind of fault. Short bursts read back after a pause separate correct ordering from pointer or address faults. Interleaved write and read bursts separate correct pointer arithmetic and wrap handling from mistakes in the full and empty comparisons. A fill to exactly the depth, read back in full, then a fill plus one extra word, tells a correct full threshold apart from one that is off by one. It also confirms that the flush discards stale contents rather than exposing them. A small instance is flushed repeatedly to separate saturation from wrap-around of the counter.

// File: rtl/afq_pkg.sv
package afq_pkg;
  typedef enum logic {WR_RUN = 1'b0, WR_FLUSH = 1'b1} wr_mode_e;
  typedef enum logic {RD_RUN = 1'b0, RD_HOLD = 1'b1} rd_mode_e;
endpackage

// File: rtl/afq_sync.sv
// Two-flop synchronizer, cleared by an asynchronous active-low reset.
module afq_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/afq_ram.sv
// Storage array: written on the producer clock, read combinationally.
module afq_ram #(
  parameter int DW = 16,
  parameter int AW = 10
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/afq_wr_ctl.sv
// Producer side: pointer, full detection, flush request and event counter.
module afq_wr_ctl
  import afq_pkg::*;
#(
  parameter int AW = 10,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [AW:0]   r_gray_s,
  input  logic          ack_s,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [AW:0]   w_gray,
  output logic          flush_tog,
  output logic [CW-1:0] flush_count
);
  wr_mode_e      mode_q, mode_d;
  logic [AW:0]   bin_q, bin_d, gray_q, gray_d;
  logic          tog_q, tog_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full;

  assign full = (gray_q == {~r_gray_s[AW:AW-1], r_gray_s[AW-2:0]});

  always_comb begin
    mode_d = mode_q;
    bin_d  = bin_q;
    gray_d = gray_q;
    tog_d  = tog_q;
    cnt_d  = cnt_q;
    mem_we = 1'b0;
    case (mode_q)
      WR_RUN: begin
        if (wr_valid) begin
          if (full) begin
            mode_d = WR_FLUSH;
            bin_d  = '0;
            gray_d = '0;
            tog_d  = ~tog_q;
            if (cnt_q != '1) cnt_d = cnt_q + 1'b1;
          end else begin
            mem_we = 1'b1;
            bin_d  = bin_q + 1'b1;
            gray_d = bin_d ^ (bin_d >> 1);
          end
        end
      end
      WR_FLUSH: begin
        if ((ack_s == tog_q) && (r_gray_s == '0)) mode_d = WR_RUN;
      end
      default: mode_d = WR_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= WR_RUN;
      bin_q  <= '0;
      gray_q <= '0;
      tog_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_d;
      bin_q  <= bin_d;
      gray_q <= gray_d;
      tog_q  <= tog_d;
      cnt_q  <= cnt_d;
    end
  end

  assign mem_addr    = bin_q[AW-1:0];
  assign w_gray      = gray_q;
  assign flush_tog   = tog_q;
  assign flush_count = cnt_q;
endmodule

// File: rtl/afq_rd_ctl.sv
// Consumer side: pointer, empty detection, flush follow-up, output register.
module afq_rd_ctl
  import afq_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req,
  input  logic [AW:0]   w_gray_s,
  input  logic          tog_s,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [AW:0]   r_gray,
  output logic          ack,
  output logic [DW-1:0] rd_data,
  output logic          rd_underflow,
  output logic          holding
);
  rd_mode_e      mode_q, mode_d;
  logic [AW:0]   bin_q, bin_d, gray_q, gray_d;
  logic          ack_q, ack_d;
  logic [DW-1:0] data_q, data_d;
  logic          uf_q, uf_d;
  logic          empty, take;

  assign empty = (mode_q == RD_HOLD) || (tog_s != ack_q) || (gray_q == w_gray_s);
  assign take  = rd_req && !empty;

  always_comb begin
    mode_d = mode_q;
    bin_d  = bin_q;
    gray_d = gray_q;
    ack_d  = ack_q;
    data_d = data_q;
    uf_d   = rd_req && empty;
    case (mode_q)
      RD_RUN: begin
        if (tog_s != ack_q) begin
          mode_d = RD_HOLD;
          bin_d  = '0;
          gray_d = '0;
        end
      end
      RD_HOLD: begin
        if (w_gray_s == '0) begin
          mode_d = RD_RUN;
          ack_d  = tog_s;
        end
      end
      default: mode_d = RD_RUN;
    endcase
    if (take) begin
      data_d = mem_rdata;
      bin_d  = bin_q + 1'b1;
      gray_d = bin_d ^ (bin_d >> 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= RD_RUN;
      bin_q  <= '0;
      gray_q <= '0;
      ack_q  <= 1'b0;
      data_q <= '0;
      uf_q   <= 1'b0;
    end else begin
      mode_q <= mode_d;
      bin_q  <= bin_d;
      gray_q <= gray_d;
      ack_q  <= ack_d;
      data_q <= data_d;
      uf_q   <= uf_d;
    end
  end

  assign mem_addr     = bin_q[AW-1:0];
  assign r_gray       = gray_q;
  assign ack          = ack_q;
  assign rd_data      = data_q;
  assign rd_underflow = uf_q;
  assign holding      = (mode_q == RD_HOLD);
endmodule

// File: rtl/afq_top.sv
module afq_top #(
  parameter int DW = 16,
  parameter int AW = 10,
  parameter int CW = 8
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  output logic [CW-1:0] flush_count,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          rd_req,
  output logic [DW-1:0] rd_data,
  output logic          rd_underflow
);
  logic          w_rst_n, r_rst_n;
  logic          mem_we;
  logic [AW-1:0] waddr, raddr;
  logic [DW-1:0] mem_rdata;
  logic [AW:0]   w_gray, w_gray_s, r_gray, r_gray_s;
  logic          flush_tog, tog_s, ack, ack_s;
  logic          rd_holding;

  // Reset assertion is immediate; release passes two flops of each clock.
  afq_sync #(.W(1)) u_wrst (.clk(wclk), .rst_n(wrst_n), .d(1'b1), .q(w_rst_n));
  afq_sync #(.W(1)) u_rrst (.clk(rclk), .rst_n(rrst_n), .d(1'b1), .q(r_rst_n));

  afq_sync #(.W(AW+1)) u_r2w_ptr (.clk(wclk), .rst_n(w_rst_n), .d(r_gray), .q(r_gray_s));
  afq_sync #(.W(1))    u_r2w_ack (.clk(wclk), .rst_n(w_rst_n), .d(ack),    .q(ack_s));
  afq_sync #(.W(AW+1)) u_w2r_ptr (.clk(rclk), .rst_n(r_rst_n), .d(w_gray), .q(w_gray_s));
  afq_sync #(.W(1))    u_w2r_tog (.clk(rclk), .rst_n(r_rst_n), .d(flush_tog), .q(tog_s));

  afq_wr_ctl #(.AW(AW), .CW(CW)) u_wr (
    .clk(wclk), .rst_n(w_rst_n), .wr_valid(wr_valid), .r_gray_s(r_gray_s),
    .ack_s(ack_s), .mem_we(mem_we), .mem_addr(waddr), .w_gray(w_gray),
    .flush_tog(flush_tog), .flush_count(flush_count)
  );

  afq_rd_ctl #(.AW(AW), .DW(DW)) u_rd (
    .clk(rclk), .rst_n(r_rst_n), .rd_req(rd_req), .w_gray_s(w_gray_s),
    .tog_s(tog_s), .mem_rdata(mem_rdata), .mem_addr(raddr), .r_gray(r_gray),
    .ack(ack), .rd_data(rd_data), .rd_underflow(rd_underflow), .holding(rd_holding)
  );

  afq_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk(wclk), .we(mem_we), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(mem_rdata)
  );
endmodule

// File: rtl/afq_checker.sv
module afq_checker #(
  parameter int DW = 16,
  parameter int CW = 8
) (
  input logic          wclk,
  input logic          wrst_n,
  input logic          rclk,
  input logic          rrst_n,
  input logic          rd_req,
  input logic [DW-1:0] rd_data,
  input logic          rd_underflow,
  input logic [CW-1:0] flush_count,
  input logic          rd_hold
);
  // R3: an underflow response leaves the data register untouched
  a_r3_underflow_keeps_data: assert property (@(posedge rclk) disable iff (!rrst_n)
    rd_underflow |-> $stable(rd_data));

  // R3: underflow is only ever a response to a request
  a_r3_underflow_needs_req: assert property (@(posedge rclk) disable iff (!rrst_n)
    rd_underflow |-> $past(rd_req));

  // R7: without a request the output word does not move
  a_r7_data_needs_req: assert property (@(posedge rclk) disable iff (!rrst_n)
    !rd_req |=> $stable(rd_data));

  // R5: while the read side waits out a flush, every request underflows
  a_r5_hold_blocks_reads: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rd_hold && rd_req) |=> rd_underflow);

  // R4: the flush counter moves by exactly one per event
  a_r4_count_single_step: assert property (@(posedge wclk) disable iff (!wrst_n)
    (flush_count != $past(flush_count)) |-> (flush_count == CW'($past(flush_count) + 1'b1)));

  // R6: once at its ceiling the counter stays there
  a_r6_count_saturates: assert property (@(posedge wclk) disable iff (!wrst_n)
    ($past(flush_count) == '1) |-> (flush_count == '1));
endmodule

bind afq_top afq_checker #(.DW(DW), .CW(CW)) u_chk (
  .wclk(wclk), .wrst_n(wrst_n), .rclk(rclk), .rrst_n(rrst_n),
  .rd_req(rd_req), .rd_data(rd_data), .rd_underflow(rd_underflow),
  .flush_count(flush_count), .rd_hold(rd_holding)
);

// File: tb/afq_top_tb.sv
module afq_top_tb;
  localparam int DW = 16;
  localparam int AW = 10;
  localparam int CW = 8;
  localparam int DEPTH = 1 << AW;

  logic wclk, rclk, wrst_n, rrst_n;
  logic wr_valid, rd_req;
  logic [DW-1:0] wr_data, rd_data;
  logic rd_underflow;
  logic [CW-1:0] flush_count;

  logic s_wr_valid, s_rd_req, s_uf;
  logic [DW-1:0] s_wr_data, s_rd_data;
  logic [2:0] s_flush_count;

  initial wclk = 1'b0;
  initial rclk = 1'b0;
  always #5 wclk = ~wclk;
  always #7 rclk = ~rclk;

  afq_top #(.DW(DW), .AW(AW), .CW(CW)) u_dut (
    .wclk(wclk), .wrst_n(wrst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .flush_count(flush_count), .rclk(rclk), .rrst_n(rrst_n), .rd_req(rd_req),
    .rd_data(rd_data), .rd_underflow(rd_underflow)
  );

  afq_top #(.DW(DW), .AW(2), .CW(3)) u_sat (
    .wclk(wclk), .wrst_n(wrst_n), .wr_valid(s_wr_valid), .wr_data(s_wr_data),
    .flush_count(s_flush_count), .rclk(rclk), .rrst_n(rrst_n), .rd_req(s_rd_req),
    .rd_data(s_rd_data), .rd_underflow(s_uf)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] exp_q [$];
  logic [DW-1:0] last_rd = '0;
  int flush_exp = 0;
  string tag = "R2";
  logic req_seen = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Driver: writes a burst and records what the buffer should then hold.
  task automatic push_burst(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      wr_valid = 1'b1;
      wr_data  = DW'(base + i);
      if (exp_q.size() == DEPTH) begin
        exp_q.delete();
        if (flush_exp < 255) flush_exp++;
      end else begin
        exp_q.push_back(DW'(base + i));
      end
    end
    @(negedge wclk);
    wr_valid = 1'b0;
  endtask

  task automatic pull(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge rclk);
      rd_req = 1'b1;
    end
    @(negedge rclk);
    rd_req = 1'b0;
  endtask

  task automatic settle();
    repeat (16) @(negedge rclk);
  endtask

  // Monitor: every served request is compared with the scoreboard queue.
  always @(posedge rclk) req_seen <= rd_req;

  always @(negedge rclk) begin
    if (req_seen && rrst_n) begin
      if (exp_q.size() > 0) begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        check(rd_data == e, tag, "read word", rd_data, e);
        check(!rd_underflow, "R7", "underflow on served read", rd_underflow, 0);
        last_rd = e;
      end else begin
        check(rd_underflow, "R3", "underflow on empty read", rd_underflow, 1);
        check(rd_data == last_rd, "R3", "repeated word", rd_data, last_rd);
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge wclk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    wrst_n = 1'b0; rrst_n = 1'b0;
    wr_valid = 1'b0; wr_data = '0; rd_req = 1'b0;
    s_wr_valid = 1'b0; s_wr_data = '0; s_rd_req = 1'b0;
    repeat (5) @(negedge wclk);
    wrst_n = 1'b1; rrst_n = 1'b1;
    settle();

    // R1: reset values
    check(rd_data == 0, "R1", "rd_data after reset", rd_data, 0);
    check(rd_underflow == 0, "R1", "underflow after reset", rd_underflow, 0);
    check(flush_count == 0, "R1", "flush_count after reset", flush_count, 0);
    check(s_flush_count == 0, "R1", "small flush_count after reset", s_flush_count, 0);

    // R2: short burst, read back in order
    tag = "R2";
    push_burst(5, 100);
    settle();
    pull(5);
    settle();
    // R3: reading an empty buffer repeats the last word
    pull(2);
    settle();
    // R7: idle cycles leave the outputs alone
    check(rd_data == last_rd, "R7", "rd_data idle", rd_data, last_rd);
    check(!rd_underflow, "R7", "underflow idle", rd_underflow, 0);

    // R2: interleaved bursts
    push_burst(3, 200);
    settle();
    pull(1);
    settle();
    push_burst(4, 300);
    settle();
    pull(6);
    settle();
    check(exp_q.size() == 0, "R2", "scoreboard drained", exp_q.size(), 0);

    // R4: exactly DEPTH words held and returned
    tag = "R4";
    push_burst(DEPTH, 1000);
    settle();
    check(flush_count == 0, "R4", "no flush at depth", flush_count, 0);
    pull(DEPTH);
    settle();
    check(exp_q.size() == 0, "R4", "full depth drained", exp_q.size(), 0);

    // R4: one word beyond the depth triggers a flush
    push_burst(DEPTH, 3000);
    settle();
    push_burst(1, 9000);
    check(flush_count == 1, "R4", "flush count after overflow", flush_count, 1);
    check(exp_q.size() == 0, "R4", "model emptied by flush", exp_q.size(), 0);
    settle();

    // R5: stale contents are gone; fresh words come through
    tag = "R5";
    pull(1);
    settle();
    push_burst(3, 6000);
    settle();
    pull(3);
    settle();
    check(last_rd == 16'd6002, "R5", "last fresh word", last_rd, 6002);

    // R6: small instance (depth 4, 3-bit counter) saturates at 7
    for (int r = 1; r <= 9; r++) begin
      for (int i = 0; i < 5; i++) begin
        @(negedge wclk);
        s_wr_valid = 1'b1;
        s_wr_data  = DW'(r * 16 + i);
      end
      @(negedge wclk);
      s_wr_valid = 1'b0;
      settle();
      check(s_flush_count == ((r < 7) ? r : 7), "R6", "saturating count",
            s_flush_count, (r < 7) ? r : 7);
    end

    finish_run();
  end
endmodule